// File: doc/BRIEF.md
# Programmable Time-Window Track Flagger

The flagger watches the digitised sample stream of a single wire, one sample per clock, during a fixed observation interval of 330 samples that begins with a start strobe. Eleven windows, each given as a start unit and an end unit in coarse units of five samples, are tested in parallel. A window's flag is raised when a run of at least four consecutive 1 samples completes inside that window.

The interval is 66 units long. A window's start unit is inclusive and its end unit is exclusive. A window wider than 43 units is treated as exactly 43 units wide, and a window whose end does not lie after its start is empty. When the last sample of the interval has been taken in, a one-clock valid pulse marks the flag vector as final. The flags then hold until the next start strobe, and samples that arrive after the interval are ignored.

Top module: `tw_flagger`

## Requirements
- R1: After reset, `flag_o` is all zero and `valid_o` is low.
- R2: In the clock after a start strobe, `flag_o` reads all zero.
- R3: The sample taken with the start strobe has index 0, and each later clock adds one to the index. Flag k is set when the samples at indices j-3, j-2, j-1 and j are all 1, j lies between 3 and 329, and floor(j/5) lies in window k's effective range.
- R4: A run of only three consecutive 1 samples sets no flag.
- R5: A run starts counting at the start strobe, so 1 samples taken before the strobe do not extend a run across it.
- R6: Window k is given by bits [7k+6:7k] of `win_lo_i` (start unit, inclusive) and of `win_hi_i` (end unit, exclusive).
- R7: When end minus start is more than 43, the effective end is start plus 43.
- R8: When the end unit is less than or equal to the start unit, the window never sets its flag.
- R9: `valid_o` is high for exactly one clock, in the clock after the sample with index 329 is taken, which is 330 clocks after the start strobe.
- R10: After the interval has ended and until the next start strobe, the sample input has no effect and `flag_o` holds its value.
- R11: Each flag responds only to its own window. A run outside a window leaves that window's flag clear.
- R12: A start strobe during an interval restarts it. The index returns to 0, the flags clear, and no valid pulse is given for the abandoned interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-interval strobe; the sample taken with it has index 0 |
| sample_i | input | 1 | Wire sample stream |
| win_lo_i | input | 77 | Start units of the eleven windows, 7 bits each |
| win_hi_i | input | 77 | End units of the eleven windows, 7 bits each |
| flag_o | output | 11 | One flag per window |
| valid_o | output | 1 | One-clock pulse when the flags are final |

## Verification
The assertions assume that the window settings do not change from a start strobe up to the valid pulse, because an empty window is checked against the settings present while its flag is read. The bench writes new windows only after an interval has ended or before the first strobe, and it gives every new setting at least one idle clock before the next strobe. The timing checks count clocks from the latest strobe. A restart in the middle of an interval is therefore legal stimulus, and the bench uses one.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int DEF_NUM_WIN   = 11;
    localparam int DEF_UNIT_W    = 7;
    localparam int DEF_SPU       = 5;   // samples per coarse unit
    localparam int DEF_NUM_UNITS = 66;  // coarse units per interval
    localparam int DEF_RUN_LEN   = 4;   // consecutive ones that make a hit
    localparam int DEF_MAX_SPAN  = 43;  // widest window in units

    // bit width able to hold 0..n-1, never below one
    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/tw_run_tracker.sv
// Counts consecutive one samples and flags each sample that completes a run
// of RUN_LEN or more. A clear restarts the count with the current sample.
module tw_run_tracker #(
    parameter int RUN_LEN = tw_pkg::DEF_RUN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    input  logic sample_i,
    output logic hit_o
);
    localparam int RW = tw_pkg::cnt_width(RUN_LEN);
    localparam logic [RW-1:0] FULL = RW'(RUN_LEN - 1);

    logic [RW-1:0] run_d, run_q;
    logic [RW-1:0] base;
    logic          full;

    always_comb begin
        base  = clr_i ? '0 : run_q;
        full  = (base == FULL);
        hit_o = en_i && sample_i && full;
        run_d = run_q;
        if (en_i) begin
            if (!sample_i)  run_d = '0;
            else if (full)  run_d = base;
            else            run_d = base + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end
endmodule

// File: rtl/tw_unit_timer.sv
// Tracks which coarse unit the current sample belongs to, and whether it is
// the final sample of the interval.
module tw_unit_timer #(
    parameter int SPU       = tw_pkg::DEF_SPU,
    parameter int NUM_UNITS = tw_pkg::DEF_NUM_UNITS,
    parameter int UNIT_W    = tw_pkg::DEF_UNIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              advance_i,
    output logic [UNIT_W-1:0] unit_o,
    output logic              last_o
);
    localparam int PH_W = tw_pkg::cnt_width(SPU);
    localparam logic [PH_W-1:0]   PH_TOP   = PH_W'(SPU - 1);
    localparam logic [UNIT_W-1:0] UNIT_TOP = UNIT_W'(NUM_UNITS - 1);

    typedef struct packed {
        logic [PH_W-1:0]   phase;
        logic [UNIT_W-1:0] unit;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [PH_W-1:0]   cur_phase;
    logic [UNIT_W-1:0] cur_unit;

    always_comb begin
        cur_phase = restart_i ? '0 : tmr_q.phase;
        cur_unit  = restart_i ? '0 : tmr_q.unit;
        unit_o    = cur_unit;
        last_o    = (cur_unit == UNIT_TOP) && (cur_phase == PH_TOP);
        tmr_d     = tmr_q;
        if (advance_i) begin
            if (cur_phase == PH_TOP) begin
                tmr_d.phase = '0;
                tmr_d.unit  = cur_unit + 1'b1;
            end else begin
                tmr_d.phase = cur_phase + 1'b1;
                tmr_d.unit  = cur_unit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/tw_window_match.sv
// Decides whether a unit lies in one window: start inclusive, end exclusive,
// span clamped to MAX_SPAN, and empty when the end is not after the start.
module tw_window_match #(
    parameter int UNIT_W   = tw_pkg::DEF_UNIT_W,
    parameter int MAX_SPAN = tw_pkg::DEF_MAX_SPAN
) (
    input  logic [UNIT_W-1:0] lo_i,
    input  logic [UNIT_W-1:0] hi_i,
    input  logic [UNIT_W-1:0] unit_i,
    output logic              in_o
);
    localparam int XW = UNIT_W + 1;
    localparam logic [XW-1:0] SPAN_MAX = XW'(MAX_SPAN);

    logic [XW-1:0] lo_x, hi_x, u_x, span, lim;

    always_comb begin
        lo_x = {1'b0, lo_i};
        hi_x = {1'b0, hi_i};
        u_x  = {1'b0, unit_i};
        span = hi_x - lo_x;
        if (hi_x > lo_x) lim = (span > SPAN_MAX) ? (lo_x + SPAN_MAX) : hi_x;
        else             lim = lo_x;
        in_o = (u_x >= lo_x) && (u_x < lim);
    end
endmodule

// File: rtl/tw_flagger.sv
module tw_flagger #(
    parameter int NUM_WIN   = tw_pkg::DEF_NUM_WIN,
    parameter int UNIT_W    = tw_pkg::DEF_UNIT_W,
    parameter int SPU       = tw_pkg::DEF_SPU,
    parameter int NUM_UNITS = tw_pkg::DEF_NUM_UNITS,
    parameter int RUN_LEN   = tw_pkg::DEF_RUN_LEN,
    parameter int MAX_SPAN  = tw_pkg::DEF_MAX_SPAN
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      sample_i,
    input  logic [NUM_WIN*UNIT_W-1:0] win_lo_i,
    input  logic [NUM_WIN*UNIT_W-1:0] win_hi_i,
    output logic [NUM_WIN-1:0]        flag_o,
    output logic                      valid_o
);
    localparam int INTERVAL = NUM_UNITS * SPU;

    typedef struct packed {
        logic               active;
        logic               valid;
        logic [NUM_WIN-1:0] flags;
    } state_t;

    state_t st_d, st_q;

    logic              proc;
    logic              run_hit;
    logic              last;
    logic [UNIT_W-1:0] cur_unit;
    logic [NUM_WIN-1:0] in_win;

    assign proc = start_i || st_q.active;

    tw_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (start_i),
        .en_i     (proc),
        .sample_i (sample_i),
        .hit_o    (run_hit)
    );

    tw_unit_timer #(.SPU(SPU), .NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (start_i),
        .advance_i (proc),
        .unit_o    (cur_unit),
        .last_o    (last)
    );

    for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
        tw_window_match #(.UNIT_W(UNIT_W), .MAX_SPAN(MAX_SPAN)) u_match (
            .lo_i   (win_lo_i[k*UNIT_W +: UNIT_W]),
            .hi_i   (win_hi_i[k*UNIT_W +: UNIT_W]),
            .unit_i (cur_unit),
            .in_o   (in_win[k])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.valid  = 1'b0;
        if (start_i) st_d.flags = '0;
        if (proc) begin
            if (run_hit) st_d.flags = st_d.flags | in_win;
            st_d.active = !last;
            st_d.valid  = last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o  = st_q.flags;
    assign valid_o = st_q.valid;
endmodule

// File: rtl/tw_flagger_chk.sv
module tw_flagger_chk #(
    parameter int NUM_WIN  = 11,
    parameter int UNIT_W   = 7,
    parameter int INTERVAL = 330
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start_i,
    input logic [NUM_WIN*UNIT_W-1:0] win_lo_i,
    input logic [NUM_WIN*UNIT_W-1:0] win_hi_i,
    input logic [NUM_WIN-1:0]        flag_o,
    input logic                      valid_o
);
    localparam int CW = $clog2(INTERVAL + 2);
    localparam logic [CW-1:0] C_END = CW'(INTERVAL);
    localparam logic [CW-1:0] C_SAT = CW'(INTERVAL + 1);
    localparam logic [CW-1:0] C_ONE = CW'(1);
    localparam logic [CW-1:0] C_THR = CW'(3);

    // clocks since the latest start strobe, 0 before any strobe
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (start_i)                     cnt_q <= C_ONE;
        else if (cnt_q != '0 && cnt_q != C_SAT) cnt_q <= cnt_q + 1'b1;
    end

    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (flag_o == '0));

    p_no_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (($past(flag_o) & ~flag_o) == '0));

    p_no_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q >= C_ONE && cnt_q <= C_THR) |-> (flag_o == '0));

    p_valid_when_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cnt_q == C_END));

    p_valid_due_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == C_END) |-> valid_o);

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q >= C_END && !start_i) |=> $stable(flag_o));

    for (genvar k = 0; k < NUM_WIN; k++) begin : g_empty
        p_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q != '0 && cnt_q <= C_END && flag_o[k])
            |-> (win_hi_i[k*UNIT_W +: UNIT_W] > win_lo_i[k*UNIT_W +: UNIT_W]));
    end
endmodule

bind tw_flagger tw_flagger_chk #(
    .NUM_WIN  (NUM_WIN),
    .UNIT_W   (UNIT_W),
    .INTERVAL (INTERVAL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .win_lo_i (win_lo_i),
    .win_hi_i (win_hi_i),
    .flag_o   (flag_o),
    .valid_o  (valid_o)
);

// File: tb/sim_tw_flagger.sv
`timescale 1ns/1ps
module sim_tw_flagger;
    localparam int NW = 11;
    localparam int UW = 7;
    localparam int NS = 330;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic sample_i = 1'b0;
    logic [NW*UW-1:0] win_lo, win_hi;
    logic [NW-1:0] flag_o;
    logic valid_o;

    logic [UW-1:0] lo [NW];
    logic [UW-1:0] hi [NW];

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int k = 0; k < NW; k++) begin
            win_lo[k*UW +: UW] = lo[k];
            win_hi[k*UW +: UW] = hi[k];
        end
    end

    tw_flagger u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sample_i(sample_i),
        .win_lo_i(win_lo), .win_hi_i(win_hi), .flag_o(flag_o), .valid_o(valid_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_default();
        for (int k = 0; k < NW; k++) begin
            lo[k] = UW'(6 * k);
            hi[k] = UW'(6 * k + 4);
        end
    endtask

    function automatic logic [NS-1:0] add_run(input logic [NS-1:0] p, input int pos, input int len);
        logic [NS-1:0] r = p;
        for (int i = pos; i < pos + len; i++) if (i < NS) r[i] = 1'b1;
        return r;
    endfunction

    // expected flags from the requirement text (R3, R6, R7, R8)
    function automatic logic [NW-1:0] model(input logic [NS-1:0] p);
        logic [NW-1:0] f = '0;
        for (int j = 3; j < NS; j++) begin
            if (p[j] && p[j-1] && p[j-2] && p[j-3]) begin
                for (int k = 0; k < NW; k++) begin
                    int l = lo[k];
                    int h = hi[k];
                    int e = (h > l) ? ((h - l > 43) ? l + 43 : h) : l;
                    if ((j / 5) >= l && (j / 5) < e) f[k] = 1'b1;
                end
            end
        end
        return f;
    endfunction

    // feeds one full interval and checks R2, R9 and the flags
    task automatic run_pat(input logic [NS-1:0] p, input string req, output logic [NW-1:0] got);
        int early = 0;
        logic [NW-1:0] exp = model(p);
        for (int k = 0; k < NS; k++) begin
            @(negedge clk);
            if (k == 1) chk("R2 flags clear after strobe", 32'(flag_o), 32'h0);
            if (k > 0 && valid_o) early++;
            start_i  = (k == 0);
            sample_i = p[k];
        end
        chk("R9 no early valid", early, 0);
        @(negedge clk);
        start_i = 1'b0;
        sample_i = 1'b0;
        chk("R9 valid after last sample", 32'(valid_o), 32'h1);
        chk(req, 32'(flag_o), 32'(exp));
        got = flag_o;
        @(negedge clk);
        chk("R9 valid one clock", 32'(valid_o), 32'h0);
    endtask

    task automatic t_reset();
        chk("R1 flags at reset", 32'(flag_o), 32'h0);
        chk("R1 valid at reset", 32'(valid_o), 32'h0);
    endtask

    task automatic t_basic();
        logic [NW-1:0] g;
        set_default();
        @(negedge clk);
        run_pat(add_run('0, 30, 4), "R3 single run", g);
        chk("R11 only window 1", 32'(g), 32'h2);
        run_pat(add_run(add_run('0, 0, 8), 245, 20), "R3 two runs", g);
    endtask

    task automatic t_short();
        logic [NW-1:0] g;
        set_default();
        run_pat(add_run(add_run('0, 30, 3), 130, 3), "R4 three ones", g);
        chk("R4 no flag", 32'(g), 32'h0);
    endtask

    task automatic t_boundary();
        logic [NW-1:0] g;
        set_default();
        lo[0] = 7'd2; hi[0] = 7'd4;
        @(negedge clk);
        run_pat(add_run('0, 6, 4), "R6 before start unit", g);
        chk("R6 index 9 outside", 32'(g[0]), 32'h0);
        run_pat(add_run('0, 7, 4), "R6 first unit", g);
        chk("R6 index 10 inside", 32'(g[0]), 32'h1);
        run_pat(add_run('0, 16, 4), "R6 last unit", g);
        chk("R6 index 19 inside", 32'(g[0]), 32'h1);
        run_pat(add_run('0, 17, 4), "R6 end exclusive", g);
        chk("R6 index 20 outside", 32'(g[0]), 32'h0);
    endtask

    task automatic t_clamp();
        logic [NW-1:0] g;
        set_default();
        lo[3] = 7'd0; hi[3] = 7'd60;
        @(negedge clk);
        run_pat(add_run('0, 211, 4), "R7 inside clamp", g);
        chk("R7 unit 42 set", 32'(g[3]), 32'h1);
        run_pat(add_run('0, 212, 4), "R7 past clamp", g);
        chk("R7 unit 43 clear", 32'(g[3]), 32'h0);
    endtask

    task automatic t_empty();
        logic [NW-1:0] g;
        set_default();
        lo[4] = 7'd30; hi[4] = 7'd10;
        lo[5] = 7'd20; hi[5] = 7'd20;
        @(negedge clk);
        run_pat({NS{1'b1}}, "R8 all ones", g);
        chk("R8 empty windows clear", 32'(g[5:4]), 32'h0);
    endtask

    task automatic t_after();
        logic [NW-1:0] g;
        logic [NW-1:0] held;
        int seen = 0;
        set_default();
        run_pat(add_run('0, 100, 5), "R3 run for hold", g);
        held = flag_o;
        sample_i = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (flag_o !== held || valid_o) seen++;
        end
        sample_i = 1'b0;
        chk("R10 ignored after interval", seen, 0);
        chk("R10 flags held", 32'(flag_o), 32'(held));
    endtask

    task automatic t_pre();
        logic [NW-1:0] g;
        set_default();
        sample_i = 1'b1;
        repeat (5) @(negedge clk);
        run_pat(add_run('0, 0, 3), "R5 no carry across strobe", g);
        chk("R5 window 0 clear", 32'(g[0]), 32'h0);
    endtask

    task automatic t_restart();
        logic [NW-1:0] g;
        set_default();
        @(negedge clk);
        for (int k = 0; k < 120; k++) begin
            start_i  = (k == 0);
            sample_i = (k >= 40 && k < 48);
            @(negedge clk);
        end
        chk("R12 flag from abandoned run", 32'(flag_o[1]), 32'h1);
        run_pat(add_run('0, 200, 4), "R12 restarted interval", g);
        chk("R12 old flag gone", 32'(g[1]), 32'h0);
    endtask

    initial begin
        set_default();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_short();
        t_boundary();
        t_clamp();
        t_empty();
        t_after();
        t_pre();
        t_restart();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule